// File: doc/BRIEF.md
# Key-Gated Indexed Register Port

This block is a small register bank that a host reaches through two I/O addresses. The first address is an index port. The second is a data port. The host writes an 8-bit register index to the index port. Every later access to the data port then reads or writes the register that index selects. The index stays latched, so repeated data-port accesses keep reaching the same register until the host loads a new index.

Two panel-control registers sit at indices A0h and A1h. They are hidden behind a key. A write of 88h through the data port while the index is 05h opens them. Any other value written there closes them again. While they are closed, the data port ignores writes to those two registers and reads them as zero. The register contents drive two parallel output buses that feed downstream panel logic. Read data comes back on a registered bus one cycle after the read strobe.

Top module: `keyed_index_port`

## Requirements
- R1: After a synchronous active-low reset, the latched index is 00h, the bank is locked, both panel outputs are 00h, and `bus_rdata` is 00h.
- R2: A write strobe at address 3D4h loads `bus_wdata` into the index. A read strobe at 3D4h returns the current index on `bus_rdata` in the following cycle.
- R3: The index changes only on a write to 3D4h. Data-port reads and writes leave it unchanged, so consecutive data-port accesses target the same register.
- R4: A data-port (3D5h) write of 88h while the index is 05h unlocks the bank. A data-port write of any other value at index 05h locks it. A data-port read at index 05h returns 01h when the bank is unlocked and 00h when it is locked.
- R5: While locked, data-port writes at index A0h or A1h leave the panel registers and outputs unchanged, and data-port reads at those indices return 00h. Values written before the lock are kept and reappear after a later unlock.
- R6: While unlocked, a data-port write at index A0h updates `panel_ctl0`, and one at index A1h updates `panel_ctl1`, from the next cycle. Data-port reads at those indices return the stored value.
- R7: A data-port read at any index other than 05h, A0h or A1h returns 00h. A data-port write at such an index changes no output and no lock state.
- R8: `bus_rdata` carries read data only in the cycle after a read strobe and is 00h in every other cycle. Strobes at addresses other than 3D4h and 3D5h change nothing, and reads there return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Host I/O address |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| panel_ctl0 | output | 8 | Contents of panel register at index A0h |
| panel_ctl1 | output | 8 | Contents of panel register at index A1h |

## Verification
The assertions take for granted that the host never raises the read and write strobes in the same cycle. This is the only input condition the block relies on, and one assertion watches for it. Each strobe lasts exactly one cycle. The bench meets both conditions by driving every access through a write task or a read task that raises one strobe on a falling edge and drops it on the next. Outside an access, the address and data buses are held at values that no check depends on.

// File: rtl/kip_pkg.sv
// Package: shared types for the key-gated indexed register port.
// Assumes: one host strobe per cycle at most.
package kip_pkg;

    // Decoded host access: which port was touched and how.
    typedef struct packed {
        logic idx_wr;   // write to the index port
        logic idx_rd;   // read of the index port
        logic dat_wr;   // write to the data port
        logic dat_rd;   // read of the data port
    } kip_strobe_t;

endpackage

// File: rtl/kip_decode.sv
// Module: kip_decode
// Turns the host address and strobes into per-port access strobes.
// Assumes: bus_wr and bus_rd are single-cycle and never both high.
module kip_decode
    import kip_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_PORT  = 16'h03D4,
    parameter int DATA_PORT = 16'h03D5
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output kip_strobe_t       strb
);

    localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_PORT);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_PORT);

    logic hit_idx;
    logic hit_dat;

    // Compare the address against both port locations.
    always_comb begin
        hit_idx = (bus_addr == IDX_A);
        hit_dat = (bus_addr == DATA_A);
    end

    // Qualify the address matches with the strobes.
    always_comb begin
        strb.idx_wr = hit_idx & bus_wr;
        strb.idx_rd = hit_idx & bus_rd;
        strb.dat_wr = hit_dat & bus_wr;
        strb.dat_rd = hit_dat & bus_rd;
    end

endmodule

// File: rtl/kip_index_reg.sv
// Module: kip_index_reg
// Holds the register index selected by the host; loads only on index-port writes.
// Assumes: synchronous active-low reset.
module kip_index_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] idx
);

    // Latch a new index on load, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load) begin
            idx <= din;
        end
    end

endmodule

// File: rtl/kip_lock.sv
// Module: kip_lock
// Tracks the unlock state set by data-port writes at the identification index.
// Assumes: writes elsewhere never alter the state; locked after reset.
module kip_lock #(
    parameter int DATA_W = 8,
    parameter int ID_IDX = 8'h05,
    parameter int KEY    = 8'h88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);

    localparam logic [DATA_W-1:0] ID_V  = DATA_W'(ID_IDX);
    localparam logic [DATA_W-1:0] KEY_V = DATA_W'(KEY);

    logic id_wr;

    // Identify a data-port write aimed at the identification register.
    always_comb begin
        id_wr = dat_wr && (idx == ID_V);
    end

    // Open on the key, close on any other value written there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (id_wr) begin
            unlocked <= (wdata == KEY_V);
        end
    end

endmodule

// File: rtl/kip_bank.sv
// Module: kip_bank
// Key-gated register bank at consecutive indices from BASE_IDX; provides read value.
// Assumes: unlocked qualifies both writes and reads; reset clears all registers.
module kip_bank #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 2,
    parameter int BASE_IDX = 8'hA0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           unlocked,
    input  logic                           dat_wr,
    input  logic [DATA_W-1:0]              idx,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    output logic                           sel_hit,
    output logic [DATA_W-1:0]              sel_val
);

    logic [NUM_REGS-1:0] hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] REG_IDX = DATA_W'(BASE_IDX + g);

        // Decode whether the current index selects this register.
        always_comb begin
            hit[g] = (idx == REG_IDX);
        end

        // Store host data only when selected and unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (dat_wr && unlocked && hit[g]) begin
                regs[g] <= wdata;
            end
        end
    end

    // Merge the selected register into one read value, gated by the lock.
    always_comb begin
        sel_hit = |hit;
        sel_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i] && unlocked) begin
                sel_val = sel_val | regs[i];
            end
        end
    end

endmodule

// File: rtl/keyed_index_port.sv
// Module: keyed_index_port
// Index/data port pair over a key-gated panel register bank with registered read data.
// Assumes: single-cycle strobes, never read and write in the same cycle.
module keyed_index_port
    import kip_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int IDX_PORT   = 16'h03D4,
    parameter int DATA_PORT  = 16'h03D5,
    parameter int ID_IDX     = 8'h05,
    parameter int KEY        = 8'h88,
    parameter int PANEL_BASE = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] panel_ctl0,
    output logic [DATA_W-1:0] panel_ctl1
);

    localparam int                NUM_PANEL = 2;
    localparam logic [DATA_W-1:0] ID_V      = DATA_W'(ID_IDX);

    kip_strobe_t                        strb;
    logic [DATA_W-1:0]                  cur_idx;
    logic                               unlocked;
    logic [NUM_PANEL-1:0][DATA_W-1:0]   panel_regs;
    logic                               bank_hit;
    logic [DATA_W-1:0]                  bank_val;
    logic [DATA_W-1:0]                  data_val;

    kip_decode #(
        .ADDR_W    (ADDR_W),
        .IDX_PORT  (IDX_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .strb     (strb)
    );

    kip_index_reg #(
        .DATA_W (DATA_W)
    ) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strb.idx_wr),
        .din   (bus_wdata),
        .idx   (cur_idx)
    );

    kip_lock #(
        .DATA_W (DATA_W),
        .ID_IDX (ID_IDX),
        .KEY    (KEY)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .dat_wr   (strb.dat_wr),
        .idx      (cur_idx),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    kip_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_PANEL),
        .BASE_IDX (PANEL_BASE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .unlocked (unlocked),
        .dat_wr   (strb.dat_wr),
        .idx      (cur_idx),
        .wdata    (bus_wdata),
        .regs     (panel_regs),
        .sel_hit  (bank_hit),
        .sel_val  (bank_val)
    );

    // Pick the data-port read value: lock status, panel register, or zero.
    always_comb begin
        if (cur_idx == ID_V) begin
            data_val = {{(DATA_W-1){1'b0}}, unlocked};
        end else if (bank_hit) begin
            data_val = bank_val;
        end else begin
            data_val = '0;
        end
    end

    // Register read data for one cycle after a read strobe, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (strb.idx_rd) begin
            bus_rdata <= cur_idx;
        end else if (strb.dat_rd) begin
            bus_rdata <= data_val;
        end else begin
            bus_rdata <= '0;
        end
    end

    // Drive the panel control outputs from the bank.
    always_comb begin
        panel_ctl0 = panel_regs[0];
        panel_ctl1 = panel_regs[1];
    end

endmodule

// File: rtl/kip_checker.sv
// Module: kip_checker
// Temporal checks on the key-gated indexed register port; bound to the top.
// Assumes: same parameter values as the instance it is bound to.
module kip_checker #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int IDX_PORT   = 16'h03D4,
    parameter int DATA_PORT  = 16'h03D5,
    parameter int ID_IDX     = 8'h05,
    parameter int KEY        = 8'h88,
    parameter int PANEL_BASE = 8'hA0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] panel_ctl0,
    input logic [DATA_W-1:0] panel_ctl1,
    input logic [DATA_W-1:0] cur_idx,
    input logic              unlocked
);

    localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_PORT);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_PORT);
    localparam logic [DATA_W-1:0] ID_V   = DATA_W'(ID_IDX);
    localparam logic [DATA_W-1:0] KEY_V  = DATA_W'(KEY);
    localparam logic [DATA_W-1:0] P0_V   = DATA_W'(PANEL_BASE);

    // R1: reset clears the outputs and the lock
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (panel_ctl0 == '0 && panel_ctl1 == '0 && bus_rdata == '0 && !unlocked));

    // R3: the index moves only on an index-port write
    a_r3_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == IDX_A) |=> $stable(cur_idx));

    // R4: the key at the identification index opens the bank
    a_r4_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_A && cur_idx == ID_V && bus_wdata == KEY_V) |=> unlocked);

    // R4: a non-key value there closes it
    a_r4_other_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_A && cur_idx == ID_V && bus_wdata != KEY_V) |=> !unlocked);

    // R5: no panel change while locked
    a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(panel_ctl0) && $stable(panel_ctl1)));

    // R6: unlocked write to the first panel register lands next cycle
    a_r6_panel0_write: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && bus_addr == DATA_A && cur_idx == P0_V)
        |=> (panel_ctl0 == $past(bus_wdata)));

    // R8: read bus is zero when no read preceded
    a_r8_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R8: index-port read returns the index
    a_r8_index_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == IDX_A) |=> (bus_rdata == $past(cur_idx)));

    // R8: input rule, never both strobes in one cycle
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

endmodule

bind keyed_index_port kip_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .IDX_PORT   (IDX_PORT),
    .DATA_PORT  (DATA_PORT),
    .ID_IDX     (ID_IDX),
    .KEY        (KEY),
    .PANEL_BASE (PANEL_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .panel_ctl0 (panel_ctl0),
    .panel_ctl1 (panel_ctl1),
    .cur_idx    (cur_idx),
    .unlocked   (unlocked)
);

// File: tb/keyed_index_port_bench.sv
`timescale 1ns/1ps
// Directed bench for keyed_index_port: one task per scenario, each self-checking.
module keyed_index_port_bench;

    localparam logic [15:0] IDX_P = 16'h03D4;
    localparam logic [15:0] DAT_P = 16'h03D5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  panel_ctl0;
    logic [7:0]  panel_ctl1;

    int checks = 0;
    int errors = 0;

    keyed_index_port u_keyed_index_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .panel_ctl0 (panel_ctl0),
        .panel_ctl1 (panel_ctl1)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
        bus_write(IDX_P, idx);
        bus_write(DAT_P, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
        bus_write(IDX_P, idx);
        bus_read(DAT_P, d);
    endtask

    task automatic test_reset();
        logic [7:0] v;
        chk("R1 panel_ctl0", panel_ctl0, 8'h00);
        chk("R1 panel_ctl1", panel_ctl1, 8'h00);
        chk("R1 rdata", bus_rdata, 8'h00);
        bus_read(IDX_P, v);
        chk("R1 index", v, 8'h00);
        bus_read(DAT_P, v);
        chk("R1 index 00 reads zero", v, 8'h00);
    endtask

    task automatic test_locked();
        logic [7:0] v;
        reg_read(8'h05, v);
        chk("R4 locked status", v, 8'h00);
        reg_write(8'hA0, 8'h5A);
        chk("R5 locked write A0", panel_ctl0, 8'h00);
        bus_read(DAT_P, v);
        chk("R5 locked read A0", v, 8'h00);
        reg_write(8'hA1, 8'h3C);
        chk("R5 locked write A1", panel_ctl1, 8'h00);
    endtask

    task automatic test_unlocked();
        logic [7:0] v;
        reg_write(8'h05, 8'h88);
        bus_read(DAT_P, v);
        chk("R4 unlocked status", v, 8'h01);
        reg_write(8'hA0, 8'h5A);
        chk("R6 panel_ctl0 written", panel_ctl0, 8'h5A);
        bus_read(DAT_P, v);
        chk("R6 read A0", v, 8'h5A);
        bus_read(DAT_P, v);
        chk("R3 repeated read same register", v, 8'h5A);
        bus_write(DAT_P, 8'h6B);
        chk("R3 second write same register", panel_ctl0, 8'h6B);
        bus_read(IDX_P, v);
        chk("R2 index read back", v, 8'hA0);
        reg_write(8'hA1, 8'hC3);
        chk("R6 panel_ctl1 written", panel_ctl1, 8'hC3);
        chk("R6 panel_ctl0 untouched", panel_ctl0, 8'h6B);
        bus_read(DAT_P, v);
        chk("R6 read A1", v, 8'hC3);
    endtask

    task automatic test_rdata_window();
        logic [7:0] v;
        bus_read(DAT_P, v);
        chk("R8 rdata in cycle after read", v, 8'hC3);
        @(negedge clk);
        chk("R8 rdata zero afterwards", bus_rdata, 8'h00);
    endtask

    task automatic test_unimplemented();
        logic [7:0] v;
        reg_write(8'h42, 8'h77);
        chk("R7 write ignored ctl0", panel_ctl0, 8'h6B);
        chk("R7 write ignored ctl1", panel_ctl1, 8'hC3);
        bus_read(DAT_P, v);
        chk("R7 read zero", v, 8'h00);
        reg_read(8'h05, v);
        chk("R7 lock unaffected", v, 8'h01);
    endtask

    task automatic test_other_address();
        logic [7:0] v;
        bus_write(IDX_P, 8'h42);
        bus_write(16'h03C4, 8'hA0);
        bus_read(IDX_P, v);
        chk("R8 foreign write leaves index", v, 8'h42);
        bus_write(16'h03D6, 8'hFF);
        chk("R8 foreign write leaves ctl0", panel_ctl0, 8'h6B);
        bus_write(IDX_P, 8'hA0);
        bus_read(16'h13D5, v);
        chk("R8 foreign read zero", v, 8'h00);
    endtask

    task automatic test_relock();
        logic [7:0] v;
        reg_write(8'h05, 8'h12);
        bus_read(DAT_P, v);
        chk("R4 relocked status", v, 8'h00);
        reg_write(8'hA0, 8'h00);
        chk("R5 relocked write ignored", panel_ctl0, 8'h6B);
        bus_read(DAT_P, v);
        chk("R5 relocked read zero", v, 8'h00);
        reg_write(8'h05, 8'h88);
        reg_read(8'hA0, v);
        chk("R5 value kept across lock", v, 8'h6B);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_locked();
        test_unlocked();
        test_rdata_window();
        test_unimplemented();
        test_other_address();
        test_relock();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule